// File: doc/BRIEF.md
# Dual Base-Limit Address Relocator

This block sits between a processor and memory. It turns every address the program issues into a physical memory address. It keeps two relocation windows, each made of a base and a size limit. The code window serves instruction fetches. The data window serves loads and stores. Because the two windows are separate, several programs can share one copy of code in memory while each keeps its own private data.

Each request is checked against the limit of the window chosen by its access type. A request that passes is relocated by adding that window's base, and it goes out as a memory request one cycle later. A request that fails produces a fault response in that same slot, marked with the access type, and no memory request is issued.

The operating system reloads all four window registers through a configuration port on each context switch. Only kernel-mode writes take effect. A write attempted in user mode is dropped and flagged.

Top module: `addr_reloc`

## Requirements
- R1: After reset all outputs are low and both limits are zero, so every fetch or data access faults until the windows are configured.
- R2: An access is legal only when its virtual address is strictly below the selected limit. An address equal to the limit faults; the limit minus one passes.
- R3: A legal access drives mem_paddr equal to the virtual address plus the selected base (for example, data base 50000 and virtual 10000 give 60000).
- R4: A request with req_is_fetch=1 uses the code window (cfg_sel 0 = code base, 1 = code limit). A request with req_is_fetch=0 uses the data window (cfg_sel 2 = data base, 3 = data limit).
- R5: The response comes exactly one cycle after req_valid. A cycle without a request produces neither mem_valid nor flt_valid on the next cycle.
- R6: A failing access raises flt_valid with mem_valid low. In that response, flt_fetch=1 marks a fetch fault and flt_fetch=0 marks a data fault.
- R7: If the base plus the virtual address does not fit in PA_W bits, the access faults instead of wrapping around.
- R8: A configuration write with cpu_kernel=0 leaves every window register unchanged. It raises priv_viol for the one following cycle. A kernel write does not raise priv_viol.
- R9: For a legal access, mem_write repeats the request's req_write bit.
- R10: A request made in the same cycle as a configuration write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | VA_W | Program-generated address |
| req_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = store, 0 = load or fetch |
| cpu_kernel | input | 1 | Processor is in kernel mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 code base, 1 code limit, 2 data base, 3 data limit |
| cfg_wdata | input | PA_W | Value to load |
| mem_valid | output | 1 | Relocated memory request valid |
| mem_paddr | output | PA_W | Physical address |
| mem_write | output | 1 | Store flag of the memory request |
| flt_valid | output | 1 | Protection fault for the previous request |
| flt_fetch | output | 1 | Fault type: 1 fetch, 0 data |
| priv_viol | output | 1 | User-mode configuration write was dropped |

## Verification
The assertions assume that inputs are stable around the rising edge and that req_is_fetch and req_write are defined whenever req_valid is high. They also assume that cfg_we and cpu_kernel are never unknown. The bench changes every input only at the falling edge and always drives all request fields to known values, including in idle cycles. It leaves req_write low for fetches, and it exercises boundaries only through legal encodings of cfg_sel.

// File: rtl/addr_reloc.sv
module addr_reloc #(
  parameter int VA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_is_fetch,
  input  logic            req_write,
  input  logic            cpu_kernel,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic            mem_valid,
  output logic [PA_W-1:0] mem_paddr,
  output logic            mem_write,
  output logic            flt_valid,
  output logic            flt_fetch,
  output logic            priv_viol
);
  localparam int PAD = PA_W - VA_W;

  logic [PA_W-1:0] code_base, code_lim, data_base, data_lim;
  logic [PA_W-1:0] sel_base, sel_lim, va_ext;
  logic [PA_W:0]   sum;
  logic            legal;

  assign va_ext   = {{PAD{1'b0}}, req_vaddr};
  assign sel_base = req_is_fetch ? code_base : data_base;
  assign sel_lim  = req_is_fetch ? code_lim  : data_lim;
  assign sum      = {1'b0, sel_base} + {1'b0, va_ext};
  assign legal    = (va_ext < sel_lim) && !sum[PA_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_base <= '0;
      code_lim  <= '0;
      data_base <= '0;
      data_lim  <= '0;
      priv_viol <= 1'b0;
    end else begin
      priv_viol <= cfg_we && !cpu_kernel;
      if (cfg_we && cpu_kernel) begin
        case (cfg_sel)
          2'd0: code_base <= cfg_wdata;
          2'd1: code_lim  <= cfg_wdata;
          2'd2: data_base <= cfg_wdata;
          default: data_lim <= cfg_wdata;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_paddr <= '0;
      mem_write <= 1'b0;
      flt_valid <= 1'b0;
      flt_fetch <= 1'b0;
    end else begin
      mem_valid <= req_valid && legal;
      flt_valid <= req_valid && !legal;
      mem_paddr <= (req_valid && legal) ? sum[PA_W-1:0] : '0;
      mem_write <= req_valid && legal && req_write;
      flt_fetch <= req_valid && !legal && req_is_fetch;
    end
  end
endmodule

module addr_reloc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_is_fetch,
  input logic req_write,
  input logic cpu_kernel,
  input logic cfg_we,
  input logic mem_valid,
  input logic mem_write,
  input logic flt_valid,
  input logic flt_fetch,
  input logic priv_viol
);
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && flt_valid));
  assert_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (mem_valid || flt_valid));
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(mem_valid || flt_valid));
  assert_ftype_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!flt_valid || (flt_fetch == $past(req_is_fetch))));
  assert_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!mem_valid || (mem_write == $past(req_write))));
  assert_viol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cpu_kernel) |=> priv_viol);
  assert_noviol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !cpu_kernel) |=> !priv_viol);
endmodule

bind addr_reloc addr_reloc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_fetch(req_is_fetch),
  .req_write(req_write), .cpu_kernel(cpu_kernel), .cfg_we(cfg_we),
  .mem_valid(mem_valid), .mem_write(mem_write), .flt_valid(flt_valid),
  .flt_fetch(flt_fetch), .priv_viol(priv_viol)
);

// File: tb/sim_addr_reloc.sv
`timescale 1ns/1ps
module sim_addr_reloc;
  localparam int VA_W = 16;
  localparam int PA_W = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_is_fetch = 0, req_write = 0, cpu_kernel = 0, cfg_we = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] cfg_sel = '0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic mem_valid, mem_write, flt_valid, flt_fetch, priv_viol;
  logic [PA_W-1:0] mem_paddr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_reloc #(.VA_W(VA_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_is_fetch(req_is_fetch), .req_write(req_write), .cpu_kernel(cpu_kernel),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_valid(mem_valid), .mem_paddr(mem_paddr), .mem_write(mem_write),
    .flt_valid(flt_valid), .flt_fetch(flt_fetch), .priv_viol(priv_viol));

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, logic [PA_W-1:0] d, logic kern);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; cpu_kernel = kern;
    @(posedge clk); @(negedge clk);
    cfg_we = 0; cpu_kernel = 0;
  endtask

  task automatic access(string tag, logic fetch, logic wr, logic [VA_W-1:0] va,
                        bit ok, logic [PA_W-1:0] pa);
    req_valid = 1; req_is_fetch = fetch; req_write = wr; req_vaddr = va;
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
    chk({tag, " mem_valid"}, mem_valid, ok);
    chk({tag, " flt_valid"}, flt_valid, !ok);
    if (ok) begin
      chk({tag, " paddr"}, mem_paddr, pa);
      chk({tag, " mem_write"}, mem_write, wr);
    end else chk({tag, " flt_fetch"}, flt_fetch, fetch);
  endtask

  task automatic t_reset();
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 flt_valid", flt_valid, 0);
    chk("R1 priv_viol", priv_viol, 0);
    access("R1 data", 0, 0, 16'd0, 0, '0);
    access("R1 fetch", 1, 0, 16'd0, 0, '0);
  endtask

  task automatic t_setup();
    cfg(2'd0, 20'h01000, 1);
    chk("R8 kernel no viol", priv_viol, 0);
    cfg(2'd1, 20'h00200, 1);
    cfg(2'd2, 20'd50000, 1);
    cfg(2'd3, 20'd20000, 1);
  endtask

  task automatic t_translate();
    access("R3 data 10000", 0, 0, 16'd10000, 1, 20'd60000);
    access("R4 fetch code", 1, 0, 16'h0010, 1, 20'h01010);
    access("R9 store", 0, 1, 16'd5, 1, 20'd50005);
  endtask

  task automatic t_bounds();
    access("R2 code lim-1", 1, 0, 16'h01FF, 1, 20'h011FF);
    access("R2 code lim", 1, 0, 16'h0200, 0, '0);
    access("R2 data lim-1", 0, 0, 16'd19999, 1, 20'd69999);
    access("R6 data lim", 0, 0, 16'd20000, 0, '0);
    access("R4 data addr above code lim", 0, 0, 16'h0300, 1, 20'd50768);
  endtask

  task automatic t_idle();
    @(posedge clk); @(negedge clk);
    chk("R5 idle mem_valid", mem_valid, 0);
    chk("R5 idle flt_valid", flt_valid, 0);
  endtask

  task automatic t_user();
    cfg(2'd2, 20'd0, 0);
    chk("R8 viol raised", priv_viol, 1);
    @(posedge clk); @(negedge clk);
    chk("R8 viol one cycle", priv_viol, 0);
    access("R8 base unchanged", 0, 0, 16'd10000, 1, 20'd60000);
  endtask

  task automatic t_overflow();
    cfg(2'd2, 20'hFFFF0, 1);
    access("R7 top fits", 0, 0, 16'h000F, 1, 20'hFFFFF);
    access("R7 wraps", 0, 0, 16'h0020, 0, '0);
  endtask

  task automatic t_same_cycle();
    cfg_we = 1; cfg_sel = 2'd2; cfg_wdata = 20'd100; cpu_kernel = 1;
    access("R10 old base", 0, 0, 16'd5, 1, 20'hFFFF5);
    cfg_we = 0; cpu_kernel = 0;
    access("R10 new base", 0, 0, 16'd5, 1, 20'd105);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_translate();
    t_bounds();
    t_idle();
    t_user();
    t_overflow();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule